// File: doc/BRIEF.md
# Strobed Parallel Receive Flow Controller

This block sits at the receiving end of a parallel data link where the sender presents a word with a strobe. A recording session is opened and closed through a start/stop command pair. While the session is live, each strobe places the presented word into an internal first-in first-out buffer. A local consumer drains that buffer through a show-ahead read port.

Back-pressure toward the sender uses an active-low suspend line. The sender is allowed to keep strobing for a fixed 16 further words after it sees suspend. For that reason suspend is raised while the buffer still has room for those 16 words plus a configurable safety margin. Suspend is released with hysteresis, and a configuration input can switch suspend signalling off entirely.

Two readiness outputs frame the session. A low-level not-ready line drops as soon as a session is opened. A user-visible ready bit rises a fixed number of cycles after that. Only the command inputs move these two outputs; the amount of traffic received never does.

Top module: `prx_flow_ctl`

## Requirements
- R1: After reset, suspend_n_o is 1, not_ready_o is 1, user_ready_o is 0, empty_o is 1, overflow_o is 0 and err_cnt_o is 0.
- R2: A start pulse while idle drives not_ready_o to 0 on the next clock edge. user_ready_o then rises exactly READY_DLY clock cycles after not_ready_o fell.
- R3: A stop pulse while a session is arming or live returns not_ready_o to 1 and user_ready_o to 0 on the next edge. Words already buffered stay readable in order.
- R4: While user_ready_o is 1, each strobe with a non-full buffer stores data_i. Words leave the read port in arrival order. rd_data_o shows the oldest word whenever empty_o is 0, and a cycle with rd_en_i high removes it.
- R5: With susp_en_i at 1, suspend_n_o goes to 0 one clock edge after the edge that makes occupancy reach DEPTH-OVERRUN-MARGIN (44 with default parameters).
- R6: After suspend is raised, OVERRUN+MARGIN further strobes (20 by default) are all stored without loss and without setting overflow_o.
- R7: Once raised, suspend_n_o stays 0 while occupancy is at least LOW_MARK (16 by default). It returns to 1 one edge after the edge that takes occupancy below LOW_MARK.
- R8: With susp_en_i at 0, suspend_n_o is 1 at any occupancy. Setting susp_en_i back to 1 while occupancy is at or above the high mark shows 0 in the same cycle.
- R9: A strobe in a live session while the buffer holds DEPTH words discards the word and sets overflow_o. overflow_o stays at 1 until reset.
- R10: Strobes while user_ready_o is 0 store nothing. Each one increments err_cnt_o, which saturates at all ones (255 with ERR_W=8).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start_i | input | 1 | One-cycle request to open a session |
| cmd_stop_i | input | 1 | One-cycle request to close a session (wins over start) |
| susp_en_i | input | 1 | 1 enables suspend signalling |
| strobe_i | input | 1 | Data strobe from the sender |
| data_i | input | DATA_W | Word presented with the strobe |
| rd_en_i | input | 1 | Remove the oldest buffered word |
| rd_data_o | output | DATA_W | Oldest buffered word (show-ahead) |
| empty_o | output | 1 | Buffer holds no words |
| suspend_n_o | output | 1 | Active-low pause request to the sender |
| not_ready_o | output | 1 | 1 while no session is open |
| user_ready_o | output | 1 | 1 while the session accepts data |
| overflow_o | output | 1 | Sticky flag: a word was dropped on a full buffer |
| err_cnt_o | output | ERR_W | Saturating count of strobes outside a session |

## Verification
The data path is exercised with three patterns: a single burst that fills the buffer to exactly DEPTH, one strobe past full, and a short burst left in the buffer across a stop command. Together they separate lost overrun words, words dropped at the wrong occupancy, and a stop that wrongly flushes data. Suspend is observed at both thresholds and one cycle either side of each, which exposes off-by-one marks and a missing hysteresis. A long run of idle strobes shows whether the error counter saturates or wraps.

// File: rtl/prx_pkg.sv
package prx_pkg;
   typedef enum logic [1:0] {
      SESS_IDLE = 2'd0,
      SESS_ARM  = 2'd1,
      SESS_LIVE = 2'd2
   } sess_e;
endpackage

// File: rtl/prx_fifo.sv
module prx_fifo #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 64,
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rdata,
   output logic [CW-1:0]     count,
   output logic              full,
   output logic              empty
);
   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic              do_wr, do_rd;

   assign full  = (count == CW'(DEPTH));
   assign empty = (count == '0);
   assign do_wr = wr_en && !full;
   assign do_rd = rd_en && !empty;
   assign rdata = mem[rd_ptr];

   generate
      if ((1 << AW) == DEPTH) begin : g_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap
         assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_wr) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_wr) wr_ptr <= wr_nxt;
         if (do_rd) rd_ptr <= rd_nxt;
         case ({do_wr, do_rd})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   // R9: occupancy never passes the storage size, and a write into a full buffer is lost
   assert_no_overflow_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));
   assert_full_drop_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (full && wr_en && !rd_en) |=> (count == CW'(DEPTH)));
endmodule

// File: rtl/prx_susp_ctl.sv
module prx_susp_ctl #(
   parameter int CW      = 7,
   parameter int HI_MARK = 44,
   parameter int LO_MARK = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] count,
   input  logic          enable,
   output logic          suspend_n
);
   logic susp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      susp_q <= 1'b0;
      else if (count >= CW'(HI_MARK))  susp_q <= 1'b1;
      else if (count <  CW'(LO_MARK))  susp_q <= 1'b0;
   end

   assign suspend_n = !(susp_q && enable);

   // R5: reaching the high mark raises the internal request on the next edge
   assert_susp_raise_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (count >= CW'(HI_MARK)) |=> susp_q);
   // R7: a raised request holds until occupancy is below the low mark
   assert_susp_hold_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (susp_q && count >= CW'(LO_MARK)) |=> susp_q);
endmodule

// File: rtl/prx_session.sv
module prx_session
   import prx_pkg::*;
#(
   parameter int READY_DLY = 150,
   localparam int DW       = $clog2(READY_DLY + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_start,
   input  logic cmd_stop,
   output logic live,
   output logic not_ready,
   output logic user_ready
);
   sess_e         state_q;
   logic [DW-1:0] dly_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SESS_IDLE;
         dly_q   <= '0;
      end else if (cmd_stop) begin
         state_q <= SESS_IDLE;
         dly_q   <= '0;
      end else begin
         case (state_q)
            SESS_IDLE: if (cmd_start) begin
               state_q <= SESS_ARM;
               dly_q   <= DW'(READY_DLY - 1);
            end
            SESS_ARM: begin
               if (dly_q == '0) state_q <= SESS_LIVE;
               else             dly_q   <= dly_q - 1'b1;
            end
            default: state_q <= state_q;
         endcase
      end
   end

   assign live       = (state_q == SESS_LIVE);
   assign user_ready = live;
   assign not_ready  = (state_q == SESS_IDLE);

   // R2: the user ready bit never rises while the not-ready line is still high
   assert_ready_order_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(user_ready) |-> !not_ready);
   // R3: a stop closes both readiness outputs on the next edge
   assert_stop_close_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_stop && !not_ready) |=> (not_ready && !user_ready));
endmodule

// File: rtl/prx_flow_ctl.sv
module prx_flow_ctl #(
   parameter int DATA_W    = 16,
   parameter int DEPTH     = 64,
   parameter int OVERRUN   = 16,
   parameter int MARGIN    = 4,
   parameter int LOW_MARK  = 16,
   parameter int READY_DLY = 150,
   parameter int ERR_W     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_start_i,
   input  logic              cmd_stop_i,
   input  logic              susp_en_i,
   input  logic              strobe_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              rd_en_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              empty_o,
   output logic              suspend_n_o,
   output logic              not_ready_o,
   output logic              user_ready_o,
   output logic              overflow_o,
   output logic [ERR_W-1:0]  err_cnt_o
);
   localparam int CW      = $clog2(DEPTH + 1);
   localparam int HI_MARK = DEPTH - OVERRUN - MARGIN;

   generate
      if (HI_MARK <= LOW_MARK) begin : g_bad_marks
         $error("prx_flow_ctl: high mark must lie above LOW_MARK");
      end
      if (LOW_MARK < 1) begin : g_bad_low
         $error("prx_flow_ctl: LOW_MARK must be at least 1");
      end
      if (READY_DLY < 1 || ERR_W < 1 || DATA_W < 1) begin : g_bad_misc
         $error("prx_flow_ctl: READY_DLY, ERR_W and DATA_W must be positive");
      end
   endgenerate

   logic          live, full;
   logic [CW-1:0] count;
   logic          ovf_q;
   logic [ERR_W-1:0] err_q;

   prx_session #(.READY_DLY(READY_DLY)) u_sess (
      .clk(clk), .rst_n(rst_n),
      .cmd_start(cmd_start_i), .cmd_stop(cmd_stop_i),
      .live(live), .not_ready(not_ready_o), .user_ready(user_ready_o)
   );

   prx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .wr_en(strobe_i && live), .wdata(data_i),
      .rd_en(rd_en_i), .rdata(rd_data_o),
      .count(count), .full(full), .empty(empty_o)
   );

   prx_susp_ctl #(.CW(CW), .HI_MARK(HI_MARK), .LO_MARK(LOW_MARK)) u_susp (
      .clk(clk), .rst_n(rst_n), .count(count),
      .enable(susp_en_i), .suspend_n(suspend_n_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_q <= 1'b0;
         err_q <= '0;
      end else begin
         if (strobe_i && live && full)          ovf_q <= 1'b1;
         if (strobe_i && !live && err_q != '1)  err_q <= err_q + 1'b1;
      end
   end

   assign overflow_o = ovf_q;
   assign err_cnt_o  = err_q;

   // R9: once set the overflow flag stays set
   assert_ovf_sticky_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      overflow_o |=> overflow_o);
   // R10: a strobe outside a session leaves a non-zero error count
   assert_idle_count_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_i && !user_ready_o) |=> (err_cnt_o != '0));
   // R8: disabled signalling never pauses the sender
   always_comb begin
      if (rst_n && !susp_en_i) assert_susp_off_R8 : assert (suspend_n_o);
   end
endmodule

// File: tb/tb_prx_flow_ctl.sv
module tb_prx_flow_ctl;
   localparam int DW    = 16;
   localparam int DEPTH = 64;
   localparam int HI    = 44;
   localparam int LO    = 16;
   localparam int EXTRA = 20;
   localparam int DLY   = 150;
   localparam int EMAX  = 255;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_start = 0, cmd_stop = 0, susp_en = 1, strobe = 0, rd_en = 0;
   logic [DW-1:0] data = '0;
   logic [DW-1:0] rd_data;
   logic empty, suspend_n, not_ready, user_ready, overflow;
   logic [7:0] err_cnt;

   int n_chk = 0, n_bad = 0, exp_err = 0;
   bit done = 0;
   logic [DW-1:0] sb[$];

   always #10 clk = ~clk;

   prx_flow_ctl dut (
      .clk(clk), .rst_n(rst_n), .cmd_start_i(cmd_start), .cmd_stop_i(cmd_stop),
      .susp_en_i(susp_en), .strobe_i(strobe), .data_i(data), .rd_en_i(rd_en),
      .rd_data_o(rd_data), .empty_o(empty), .suspend_n_o(suspend_n),
      .not_ready_o(not_ready), .user_ready_o(user_ready),
      .overflow_o(overflow), .err_cnt_o(err_cnt)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // monitor: every word leaving the read port must match the scoreboard head (R4)
   always @(negedge clk) begin
      if (rst_n && rd_en && !empty) begin
         n_chk++;
         if (sb.size() == 0) begin
            n_bad++;
            $display("FAIL R4: actual word %h expected none", rd_data);
         end else begin
            if (rd_data != sb[0]) begin
               n_bad++;
               $display("FAIL R4: actual %h expected %h", rd_data, sb[0]);
            end
            void'(sb.pop_front());
         end
      end
   end

   task automatic tick();
      @(posedge clk); #5;
   endtask

   task automatic put(input logic [DW-1:0] w);
      if (user_ready && sb.size() < DEPTH) sb.push_back(w);
      if (!user_ready) exp_err = (exp_err < EMAX) ? exp_err + 1 : EMAX;
      strobe = 1; data = w; tick(); strobe = 0;
   endtask

   task automatic take(input int n);
      rd_en = 1;
      for (int i = 0; i < n; i++) tick();
      rd_en = 0;
   endtask

   task automatic open_session();
      int n;
      cmd_start = 1; tick(); cmd_start = 0;
      chk("R2 not_ready falls", not_ready, 0);
      chk("R2 ready still low", user_ready, 0);
      n = 0;
      while (!user_ready && n < DLY + 10) begin tick(); n++; end
      chk("R2 stagger cycles", n, DLY);
   endtask

   initial begin
      #(20 * 200000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      if (!done) begin
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #5;
      chk("R1 suspend_n", suspend_n, 1);
      chk("R1 not_ready", not_ready, 1);
      chk("R1 user_ready", user_ready, 0);
      chk("R1 empty", empty, 1);
      chk("R1 overflow", overflow, 0);
      chk("R1 err_cnt", err_cnt, 0);
      rst_n = 1; tick();

      // R10: strobes before a session
      for (int i = 0; i < 3; i++) put(16'h0BAD);
      chk("R10 idle ignored", empty, 1);
      chk("R10 err count", err_cnt, exp_err);

      open_session();

      // R5: fill to the high mark
      for (int i = 0; i < HI; i++) put(16'hA000 + 16'(i));
      chk("R5 not yet raised", suspend_n, 1);
      tick();
      chk("R5 raised", suspend_n, 0);

      // R6: overrun allowance stored
      for (int i = 0; i < EXTRA; i++) put(16'hB000 + 16'(i));
      chk("R6 no overflow", overflow, 0);
      chk("R6 still paused", suspend_n, 0);

      // R9: one past full
      put(16'hDEAD);
      chk("R9 overflow set", overflow, 1);

      // R7: hysteresis on drain
      take(DEPTH - LO);
      chk("R7 held at low mark", suspend_n, 0);
      take(1);
      chk("R7 held one more edge", suspend_n, 0);
      tick();
      chk("R7 released", suspend_n, 1);
      take(LO - 1);
      chk("R4 drained", empty, 1);
      chk("R4 scoreboard empty", sb.size(), 0);

      // R3: stop keeps buffered words
      put(16'hC001); put(16'hC002);
      cmd_stop = 1; tick(); cmd_stop = 0;
      chk("R3 not_ready back", not_ready, 1);
      chk("R3 ready cleared", user_ready, 0);
      chk("R3 words kept", empty, 0);
      put(16'h0BAD);
      chk("R10 err after stop", err_cnt, exp_err);
      take(2);
      chk("R3 words read out", sb.size(), 0);

      // R8: disabled signalling
      open_session();
      susp_en = 0;
      for (int i = 0; i < 50; i++) put(16'hE000 + 16'(i));
      tick();
      chk("R8 stays high", suspend_n, 1);
      susp_en = 1; #1;
      chk("R8 reenabled", suspend_n, 0);
      take(50);
      chk("R9 sticky", overflow, 1);

      // R10: saturation
      cmd_stop = 1; tick(); cmd_stop = 0;
      for (int i = 0; i < 300; i++) put(16'h0BAD);
      chk("R10 saturated", err_cnt, EMAX);
      chk("R10 model", exp_err, EMAX);
      chk("R10 nothing stored", empty, 1);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule